// File: doc/BRIEF.md
# Interrupt Acknowledge Gating and Vector-Call Sequencer

This block sits beside an instruction sequencer. It decides on which instruction boundary a pending interrupt request is acknowledged. The sequencer reports three things: each instruction completion, whether the core is in the closing four state times of the current instruction, and a class code for the instruction that is completing.

A request is taken only at a completion. Three cases push the acknowledge out by one boundary:
- the request first showed up inside the closing window;
- the completing instruction belongs to a deferring class;
- an atomic transfer cycle is still running.

Once a request is acknowledged, the block does one of two things:
- For a normal request, it runs a fixed vector-call sequence. This lasts 11 state times, or 13 when the stack lives in external memory. No further acknowledge is possible while it runs.
- For a request owned by the transfer server, it instead pulses a transfer-start strobe in the same cycle as the acknowledge, with no call sequence.

One clock equals one state time. The controlling machine has three states:
- `S_OPEN`: acknowledge may be given.
- `S_DEFER`: the last completion was a deferring class.
- `S_CALL`: the vector call is in progress.

Its transitions are:
- OPEN→DEFER: a completion of a deferring class.
- DEFER→OPEN: a completion of a non-deferring class.
- OPEN/DEFER→CALL: acknowledge of a normal request.
- CALL→OPEN: the call counter reaches its last state.

Completion strobes are ignored while in CALL.

Top module: `irq_ack_seq`

## Requirements
- R1: `ack` is a one-cycle pulse and appears only in the cycle right after a cycle with `insn_done` high. It needs a request that is pending, armed and not blocked.
- R2: A request becomes armed when it is seen pending with `late_window` low, or when it is pending at a completion. A request first raised during `late_window` and not armed before the completion is not acknowledged at that completion. It is acknowledged at the next one.
- R3: Class codes (3 bits) have fixed meanings:
  - 1 = signed-operation prefix
  - 2 = protected instruction (interrupt/transfer enable or disable, push/pop of all registers or flags)
  - 3 = logical read-modify-write
  - 4 = unimplemented opcode
  - 5 = software trap

  These five codes defer: no acknowledge at their own completion. Codes 0, 6 and 7 do not defer.
- R4: A deferred request is acknowledged at the next completion whose class does not defer. A run of deferring completions keeps deferring.
- R5: With `stack_ext` low, `call_busy` is high for exactly 11 cycles, starting in the `ack` cycle of a normal request.
- R6: With `stack_ext` high, `call_busy` is high for exactly 13 cycles.
- R7: A request with `irq_is_xfer` high raises `xfer_start` in the same cycle as `ack`, and `call_busy` stays low.
- R8: While `xfer_busy` is high, no acknowledge is given. The request is acknowledged at the first completion after `xfer_busy` falls.
- R9: While `call_busy` is high, completions are ignored and no `ack` is issued.
- R10: After reset, `ack`, `xfer_start` and `call_busy` are low.
- R11: A request withdrawn before a completion is not acknowledged at that completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State-time clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_done | input | 1 | Instruction completes this cycle |
| late_window | input | 1 | Core is in the closing four state times |
| insn_class | input | CLASS_W | Class code of the completing instruction |
| irq_pend | input | 1 | Highest-priority request is pending |
| irq_is_xfer | input | 1 | Pending request is served by the transfer server |
| xfer_busy | input | 1 | Atomic transfer cycle in progress |
| stack_ext | input | 1 | Stack resides in external memory |
| ack | output | 1 | Acknowledge pulse |
| xfer_start | output | 1 | Transfer-server start pulse |
| call_busy | output | 1 | Vector-call sequence in progress |

## Verification
Several internal faults show up at the ports within one or two completions:
- A wrong state register gives an acknowledge at a boundary where it should be held, or misses one.
- A stale armed flag does the same, at the very next completion.
- A wrong call counter changes how long `call_busy` stays high. This is seen 11 or 13 cycles after the acknowledge, when the strobe falls early or late.

The bench sweeps every class code against both stack locations. It measures each call length in cycles and runs the late-arrival, withdrawal, transfer-busy, transfer-start and mid-call cases.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [1:0] {
        S_OPEN  = 2'd0,
        S_DEFER = 2'd1,
        S_CALL  = 2'd2
    } seq_state_e;

    localparam int unsigned CLS_PREFIX   = 1;
    localparam int unsigned CLS_PROTECT  = 2;
    localparam int unsigned CLS_LOGIC_RMW = 3;
    localparam int unsigned CLS_BADOP    = 4;
    localparam int unsigned CLS_TRAP     = 5;

    function automatic logic class_defers(input int unsigned cls);
        return (cls >= CLS_PREFIX) && (cls <= CLS_TRAP);
    endfunction

endpackage

// File: rtl/irq_arm_track.sv
module irq_arm_track (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_pend,
    input  logic late_window,
    input  logic insn_done,
    input  logic fire,
    output logic armed
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else
            armed_q <= irq_pend & ~fire & (armed_q | ~late_window | insn_done);
    end

    assign armed = armed_q;

    // R11: a withdrawn request never stays armed
    p_drop_disarms_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pend |=> !armed_q);
endmodule

// File: rtl/call_timer.sv
module call_timer #(
    parameter int unsigned CALL_BASE   = 11,
    parameter int unsigned STACK_EXTRA = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic stack_ext,
    output logic last
);
    localparam int unsigned LEN_MAX = CALL_BASE + STACK_EXTRA;
    localparam int unsigned CNT_W   = $clog2(LEN_MAX + 1);
    localparam logic [CNT_W-1:0] LOAD_INT = CNT_W'(CALL_BASE - 1);
    localparam logic [CNT_W-1:0] LOAD_EXT = CNT_W'(LEN_MAX - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= stack_ext ? LOAD_EXT : LOAD_INT;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);

    // R6: the count never exceeds the longer call length
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(LEN_MAX));
    // R5: a nonzero count always moves down by one
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int unsigned CLASS_W     = 3,
    parameter int unsigned CALL_BASE   = 11,
    parameter int unsigned STACK_EXTRA = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_done,
    input  logic               late_window,
    input  logic [CLASS_W-1:0] insn_class,
    input  logic               irq_pend,
    input  logic               irq_is_xfer,
    input  logic               xfer_busy,
    input  logic               stack_ext,
    output logic               ack,
    output logic               xfer_start,
    output logic               call_busy
);
    seq_state_e state_q, state_d;
    logic       armed;
    logic       cls_defer;
    logic       fire;
    logic       call_load;
    logic       tmr_last;
    logic       ack_q, xs_q;

    assign cls_defer = class_defers(32'(insn_class));
    assign fire      = insn_done & irq_pend & armed & ~xfer_busy
                     & ~cls_defer & (state_q != S_CALL);
    assign call_load = fire & ~irq_is_xfer;

    irq_arm_track u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pend   (irq_pend),
        .late_window(late_window),
        .insn_done  (insn_done),
        .fire       (fire),
        .armed      (armed)
    );

    call_timer #(
        .CALL_BASE  (CALL_BASE),
        .STACK_EXTRA(STACK_EXTRA)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (call_load),
        .stack_ext(stack_ext),
        .last     (tmr_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OPEN: begin
                if (call_load)                    state_d = S_CALL;
                else if (insn_done && cls_defer)  state_d = S_DEFER;
            end
            S_DEFER: begin
                if (call_load)                    state_d = S_CALL;
                else if (insn_done && !cls_defer) state_d = S_OPEN;
            end
            S_CALL: begin
                if (tmr_last)                     state_d = S_OPEN;
            end
            default:                              state_d = S_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OPEN;
        else        state_q <= state_d;
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            xs_q  <= 1'b0;
        end else begin
            ack_q <= fire;
            xs_q  <= fire & irq_is_xfer;
        end
    end

    assign ack        = ack_q;
    assign xfer_start = xs_q;
    assign call_busy  = (state_q == S_CALL);

    // R1: acknowledge only follows a completion
    p_ack_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(insn_done));
    // R1: acknowledge is a single-cycle pulse
    p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R3: deferring classes never acknowledge at their own completion
    p_defer_cls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !class_defers(32'($past(insn_class))));
    // R7: transfer start coincides with acknowledge, no call
    p_xfer_with_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> (ack && !call_busy));
    // R8: a busy transfer cycle blocks acknowledge
    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !$past(xfer_busy));
    // R9: no acknowledge inside the call sequence
    p_no_ack_in_call_r9: assert property (@(posedge clk) disable iff (!rst_n)
        call_busy |=> !ack);
endmodule

// File: tb/tb_irq_ack_seq.sv
module tb_irq_ack_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       insn_done = 1'b0;
    logic       late_window = 1'b0;
    logic [2:0] insn_class = 3'd0;
    logic       irq_pend = 1'b0;
    logic       irq_is_xfer = 1'b0;
    logic       xfer_busy = 1'b0;
    logic       stack_ext = 1'b0;
    logic       ack, xfer_start, call_busy;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    irq_ack_seq dut (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done),
        .late_window(late_window), .insn_class(insn_class),
        .irq_pend(irq_pend), .irq_is_xfer(irq_is_xfer),
        .xfer_busy(xfer_busy), .stack_ext(stack_ext),
        .ack(ack), .xfer_start(xfer_start), .call_busy(call_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic arm_req(input bit xf);
        irq_pend = 1'b1; irq_is_xfer = xf; late_window = 1'b0;
        step();
    endtask

    task automatic finish_insn(input int cls, output bit got_ack, output bit got_xs);
        insn_done = 1'b1; insn_class = 3'(cls); late_window = 1'b1;
        step();
        got_ack = ack; got_xs = xfer_start;
        insn_done = 1'b0; late_window = 1'b0; insn_class = 3'd0;
        if (got_ack) irq_pend = 1'b0;
    endtask

    task automatic measure_call(output int n);
        n = 0;
        while (call_busy && n < 100) begin
            n++;
            step();
        end
    endtask

    initial begin
        bit a, x;
        int n;
        step(); step();
        chk("R10 ack", ack, 0);
        chk("R10 xfer_start", xfer_start, 0);
        chk("R10 call_busy", call_busy, 0);
        rst_n = 1'b1;
        step();

        // R3 R4 R5 R6: every class against both stack locations
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 8; c++) begin
                bit dfr;
                stack_ext = s[0];
                dfr = (c >= 1 && c <= 5);
                arm_req(1'b0);
                finish_insn(c, a, x);
                chk($sformatf("R3 class %0d ack", c), a, dfr ? 0 : 1);
                if (!a) begin
                    finish_insn(0, a, x);
                    chk("R4 ack after defer", a, 1);
                end
                chk("R7 no xfer_start on normal", x, 0);
                measure_call(n);
                chk(s ? "R6 call length ext" : "R5 call length int", n, s ? 13 : 11);
                step();
            end
        end
        stack_ext = 1'b0;

        // R4: chain of deferring completions
        arm_req(1'b0);
        finish_insn(1, a, x); chk("R4 chain prefix", a, 0);
        finish_insn(2, a, x); chk("R4 chain protected", a, 0);
        finish_insn(5, a, x); chk("R4 chain trap", a, 0);
        finish_insn(6, a, x); chk("R4 chain release", a, 1);
        measure_call(n); step();

        // R2: request first raised at a completion in the late window
        irq_pend = 1'b1; irq_is_xfer = 1'b0;
        finish_insn(0, a, x); chk("R2 late arrival held", a, 0);
        finish_insn(0, a, x); chk("R2 late arrival next", a, 1);
        measure_call(n); step();

        // R2: request raised inside the window a few cycles before completion
        late_window = 1'b1; irq_pend = 1'b1;
        step(); step();
        finish_insn(0, a, x); chk("R2 window arrival held", a, 0);
        finish_insn(0, a, x); chk("R2 window arrival next", a, 1);
        measure_call(n); step();

        // R11: withdrawn request
        arm_req(1'b0);
        irq_pend = 1'b0; step();
        finish_insn(0, a, x); chk("R11 withdrawn no ack", a, 0);
        chk("R11 no call", call_busy, 0);

        // R8: transfer busy blocks acknowledge
        arm_req(1'b0);
        xfer_busy = 1'b1;
        finish_insn(0, a, x); chk("R8 blocked while busy", a, 0);
        finish_insn(0, a, x); chk("R8 still blocked", a, 0);
        xfer_busy = 1'b0;
        finish_insn(0, a, x); chk("R8 ack after busy", a, 1);
        measure_call(n); step();

        // R7: transfer-server request
        arm_req(1'b1);
        finish_insn(0, a, x);
        chk("R7 ack", a, 1);
        chk("R7 xfer_start", x, 1);
        chk("R7 call_busy low", call_busy, 0);
        irq_is_xfer = 1'b0;
        step();
        chk("R7 xfer_start pulse", xfer_start, 0);
        chk("R1 ack pulse", ack, 0);

        // R9: completions during the call are ignored
        arm_req(1'b0);
        finish_insn(0, a, x); chk("R9 first ack", a, 1);
        arm_req(1'b0);
        finish_insn(0, a, x); chk("R9 no ack in call", a, 0);
        finish_insn(3, a, x); chk("R9 class ignored in call", a, 0);
        measure_call(n); chk("R9 call length kept", n, 11 - 3);
        finish_insn(0, a, x); chk("R9 ack after call", a, 1);
        measure_call(n); step();

        // R1: no ack without a completion
        arm_req(1'b0);
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R1 no ack between completions", ack, 0);
        end
        irq_pend = 1'b0;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule